// File: doc/BRIEF.md
# Transmit Low Power Idle Controller

This block decides when an Ethernet transmit MAC drops into Energy Efficient Ethernet low power idle and when it comes back out. It measures how long the transmit path has been idle, in units of an external tick pulse, and compares that count with a programmable threshold. It raises an LPI request toward the PHY side only when three policy inputs allow it: EEE enabled, EEE negotiated at the current speed, and transmit LPI enabled. A force control bit makes the block skip the idle wait.

The link speed input selects the entry style. At 100 Mbit/s the local side enters LPI on its own, without regard to the link partner. At 1000 Mbit/s entry waits until a partner-ready input shows that both sides can enter together. Exit happens when a frame becomes pending or when any policy input drops. After exit, a wake-hold counter of programmable length keeps transmit-ready low while the PHY wakes.

Software programs the block through a write-only bus with a one-bit address.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset, lpi_req_o is 0 and tx_ready_o is 1. The threshold, the force bit and the wake length all reset to 0.
- R2: A write to address 0 loads the threshold from cfg_wdata_i. If the value is above 0xFFF, the write is discarded and the previous threshold is kept.
- R3: With force at 0, the idle count rises by one on each clock where tick_i=1, tx_pending_i=0 and tx_ready_o=1, and it clears in any other cycle where pending is high or ready is low. LPI is entered on the clock after the count exceeds the threshold. With a tick on every cycle, lpi_req_o is first seen high threshold+2 cycles after pending drops.
- R4: A write to address 1 sets force from bit 0 and the wake length from bits 11:4. With force at 1, LPI is entered on the first clock where nothing is pending, and the threshold is ignored.
- R5: LPI is never entered while eee_en_i, eee_neg_i or tx_lpi_en_i is 0.
- R6: With speed_gig_i=0, entry ignores partner_rdy_i.
- R7: With speed_gig_i=1, entry waits until partner_rdy_i=1.
- R8: If tx_pending_i is 1 while lpi_req_o is 1, lpi_req_o goes to 0 on the next clock.
- R9: After lpi_req_o falls, tx_ready_o stays 0 for wake length + 1 cycles and then returns to 1. lpi_req_o and tx_ready_o are never 1 in the same cycle.
- R10: If any policy input drops while lpi_req_o is 1, the block exits through the same wake sequence.
- R11: When tx_pending_i rises in the same cycle that the entry condition would otherwise be met, the pending frame wins and no LPI is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Idle time base pulse |
| tx_pending_i | input | 1 | Frame waiting or being sent |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 1 | 0 selects the threshold, 1 selects control |
| cfg_wdata_i | input | 16 | Write data |
| eee_en_i | input | 1 | EEE enabled by policy |
| eee_neg_i | input | 1 | EEE negotiated at the current speed |
| tx_lpi_en_i | input | 1 | Transmit LPI allowed |
| speed_gig_i | input | 1 | 1 = 1000 Mbit/s (symmetric), 0 = 100 Mbit/s (asymmetric) |
| partner_rdy_i | input | 1 | Link partner ready for joint entry |
| lpi_req_o | output | 1 | LPI request to the PHY side |
| tx_ready_o | output | 1 | MAC may transmit |

## Verification
Two events can land on the same clock: the entry decision, when the idle count crosses the threshold, and a frame arrival that should start a wake or block entry. The bench sets a threshold, releases pending, and raises pending again exactly one cycle before the entry clock. It then checks that lpi_req_o never rises. Policy inputs are also dropped while LPI is active, to confirm that this exit reuses the wake hold. Every cycle is compared against a behavioural model.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;
  typedef enum logic [1:0] {
    ST_ACT  = 2'd0,
    ST_LPI  = 2'd1,
    ST_WAKE = 2'd2
  } lpi_state_e;

  localparam logic ADDR_THRESH = 1'b0;
  localparam logic ADDR_CTRL   = 1'b1;
endpackage

// File: rtl/eee_lpi_cfg.sv
module eee_lpi_cfg #(
  parameter int DATA_W   = 16,
  parameter int THRESH_W = 12,
  parameter int WAKE_W   = 8,
  parameter int WAKE_LSB = 4,
  parameter int FORCE_BIT = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic                addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [THRESH_W-1:0] thresh_o,
  output logic                force_o,
  output logic [WAKE_W-1:0]   wake_len_o
);
  import eee_lpi_pkg::*;

  localparam logic [DATA_W-1:0] THR_MAX = DATA_W'((1 << THRESH_W) - 1);

  logic thr_ok;
  assign thr_ok = (wdata_i <= THR_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thresh_o   <= '0;
      force_o    <= 1'b0;
      wake_len_o <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_THRESH) begin
        if (thr_ok) thresh_o <= wdata_i[THRESH_W-1:0];
      end else begin
        force_o    <= wdata_i[FORCE_BIT];
        wake_len_o <= wdata_i[WAKE_LSB +: WAKE_W];
      end
    end
  end
endmodule

// File: rtl/eee_lpi_idle.sv
module eee_lpi_idle #(
  parameter int THRESH_W = 12,
  localparam int CNT_W   = THRESH_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                clear_i,
  input  logic [THRESH_W-1:0] thresh_i,
  output logic                expired_o
);
  logic [CNT_W-1:0] cnt_q;

  // saturating so a long idle never wraps below the threshold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clear_i)         cnt_q <= '0;
    else if (tick_i && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q > {1'b0, thresh_i});
endmodule

// File: rtl/eee_lpi_fsm.sv
module eee_lpi_fsm #(
  parameter int WAKE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_ok_i,
  input  logic              pending_i,
  input  logic              enter_ok_i,
  input  logic [WAKE_W-1:0] wake_len_i,
  output logic              lpi_o,
  output logic              ready_o
);
  import eee_lpi_pkg::*;

  lpi_state_e        st_q, st_d;
  logic [WAKE_W-1:0] wcnt_q, wcnt_d;

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    unique case (st_q)
      ST_ACT: begin
        if (enter_ok_i) st_d = ST_LPI;
      end
      ST_LPI: begin
        if (pending_i || !gate_ok_i) begin
          st_d   = ST_WAKE;
          wcnt_d = wake_len_i;
        end
      end
      ST_WAKE: begin
        if (wcnt_q == '0) st_d = ST_ACT;
        else              wcnt_d = wcnt_q - 1'b1;
      end
      default: st_d = ST_ACT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_ACT;
      wcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
    end
  end

  assign lpi_o   = (st_q == ST_LPI);
  assign ready_o = (st_q == ST_ACT);
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl #(
  parameter int DATA_W    = 16,
  parameter int THRESH_W  = 12,
  parameter int WAKE_W    = 8,
  parameter int WAKE_LSB  = 4,
  parameter int FORCE_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              tx_pending_i,
  input  logic              cfg_we_i,
  input  logic              cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              eee_en_i,
  input  logic              eee_neg_i,
  input  logic              tx_lpi_en_i,
  input  logic              speed_gig_i,
  input  logic              partner_rdy_i,
  output logic              lpi_req_o,
  output logic              tx_ready_o
);
  logic [THRESH_W-1:0] thresh;
  logic                force_now;
  logic [WAKE_W-1:0]   wake_len;
  logic                expired, gate_ok, sync_ok, enter_ok, idle_clr;

  eee_lpi_cfg #(
    .DATA_W(DATA_W), .THRESH_W(THRESH_W), .WAKE_W(WAKE_W),
    .WAKE_LSB(WAKE_LSB), .FORCE_BIT(FORCE_BIT)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .thresh_o(thresh), .force_o(force_now), .wake_len_o(wake_len)
  );

  assign idle_clr = tx_pending_i || !tx_ready_o;

  eee_lpi_idle #(.THRESH_W(THRESH_W)) u_idle (
    .clk_i, .rst_ni,
    .tick_i, .clear_i(idle_clr), .thresh_i(thresh), .expired_o(expired)
  );

  assign gate_ok  = eee_en_i && eee_neg_i && tx_lpi_en_i;
  // symmetric entry at gigabit waits for the partner
  assign sync_ok  = !speed_gig_i || partner_rdy_i;
  assign enter_ok = gate_ok && sync_ok && !tx_pending_i && (force_now || expired);

  eee_lpi_fsm #(.WAKE_W(WAKE_W)) u_fsm (
    .clk_i, .rst_ni,
    .gate_ok_i(gate_ok), .pending_i(tx_pending_i), .enter_ok_i(enter_ok),
    .wake_len_i(wake_len), .lpi_o(lpi_req_o), .ready_o(tx_ready_o)
  );
endmodule

// File: rtl/eee_lpi_ctrl_chk.sv
module eee_lpi_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_pending_i,
  input logic eee_en_i,
  input logic eee_neg_i,
  input logic tx_lpi_en_i,
  input logic speed_gig_i,
  input logic partner_rdy_i,
  input logic lpi_req_o,
  input logic tx_ready_o
);
  logic pol;
  assign pol = eee_en_i && eee_neg_i && tx_lpi_en_i;

  // R5
  gate_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lpi_req_o && !pol |=> !lpi_req_o);
  // R10
  gate_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lpi_req_o && !pol |=> !lpi_req_o && !tx_ready_o);
  // R8
  wake_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lpi_req_o && tx_pending_i |=> !lpi_req_o && !tx_ready_o);
  // R7
  sym_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lpi_req_o && speed_gig_i && !partner_rdy_i |=> !lpi_req_o);
  // R11
  pend_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lpi_req_o && tx_pending_i |=> !lpi_req_o);
  // R9
  ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lpi_req_o && tx_ready_o));
  // R9
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lpi_req_o) |-> !tx_ready_o);
endmodule

bind eee_lpi_ctrl eee_lpi_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_pending_i(tx_pending_i),
  .eee_en_i(eee_en_i), .eee_neg_i(eee_neg_i), .tx_lpi_en_i(tx_lpi_en_i),
  .speed_gig_i(speed_gig_i), .partner_rdy_i(partner_rdy_i),
  .lpi_req_o(lpi_req_o), .tx_ready_o(tx_ready_o)
);

// File: tb/eee_lpi_ctrl_bench.sv
module eee_lpi_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, pend = 1'b1, we = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0;
  logic eee = 1'b1, neg = 1'b1, txlpi = 1'b1, gig = 1'b0, prdy = 1'b0;
  logic lpi, rdy;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  always #4 clk = ~clk; // 125 MHz

  eee_lpi_ctrl u_eee_lpi_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .tx_pending_i(pend),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .eee_en_i(eee), .eee_neg_i(neg), .tx_lpi_en_i(txlpi),
    .speed_gig_i(gig), .partner_rdy_i(prdy),
    .lpi_req_o(lpi), .tx_ready_o(rdy)
  );

  // behavioural reference: 0 active, 1 lpi, 2 wake
  int m_st, m_idle, m_wc, m_thr, m_wlen;
  bit m_force;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_idle = 0; m_wc = 0; m_thr = 0; m_wlen = 0; m_force = 0;
    end else begin
      bit ok;
      int old_st;
      ok = eee && neg && txlpi;
      old_st = m_st;
      if (m_st == 0) begin
        if (ok && !pend && (m_force || m_idle > m_thr) && (!gig || prdy)) m_st = 1;
      end else if (m_st == 1) begin
        if (pend || !ok) begin m_st = 2; m_wc = m_wlen; end
      end else begin
        if (m_wc == 0) m_st = 0; else m_wc = m_wc - 1;
      end
      if (pend || old_st != 0) m_idle = 0;
      else if (tick && m_idle < 8191) m_idle = m_idle + 1;
      if (we) begin
        if (!addr) begin if (wdata <= 16'hFFF) m_thr = wdata; end
        else begin m_force = wdata[0]; m_wlen = wdata[11:4]; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (lpi !== (m_st == 1) || rdy !== (m_st == 0)) begin
        errors++;
        $display("FAIL %s model: lpi/rdy act %0b%0b exp %0b%0b",
                 cur_req, lpi, rdy, (m_st == 1), (m_st == 0));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog act hung exp done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit c, input string r, input int act, input int exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", r, act, exp);
    end
  endtask

  task automatic drv; @(negedge clk); #2; endtask

  task automatic wr(input logic a, input logic [15:0] d);
    drv(); we = 1'b1; addr = a; wdata = d;
    drv(); we = 1'b0;
  endtask

  task automatic until_lpi(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); n++;
      if (lpi) break;
    end
  endtask

  task automatic until_rdy(output int n);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); n++;
      if (rdy) break;
    end
  endtask

  task automatic stay_low(input int cycles, input string r);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin @(negedge clk); if (lpi) seen = 1; end
    chk(!seen, r, seen, 0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk(lpi == 0 && rdy == 1, "R1", {lpi, rdy}, 1);

    // R2: accepted then rejected threshold writes
    cur_req = "R2";
    wr(1'b0, 16'd5);
    wr(1'b0, 16'h1000);
    wr(1'b0, 16'hFFFF);
    cur_req = "R3";
    drv(); pend = 1'b0;
    until_lpi(n);
    chk(n == 7, "R2 R3 threshold 5 kept", n, 7);

    // R8 / R9 wake with length 3
    cur_req = "R9";
    wr(1'b1, 16'h0030);
    drv(); pend = 1'b1;
    @(negedge clk);
    chk(lpi == 0, "R8", lpi, 0);
    until_rdy(n);
    chk(n == 4, "R9 wake hold", n + 1, 5);

    // R4 force
    cur_req = "R4";
    wr(1'b1, 16'h0031);
    drv(); pend = 1'b0;
    until_lpi(n);
    chk(n == 1, "R4 force", n, 1);

    // R10 / R5 gating
    cur_req = "R10";
    drv(); eee = 1'b0;
    @(negedge clk);
    chk(lpi == 0 && rdy == 0, "R10 exit", {lpi, rdy}, 0);
    until_rdy(n);
    chk(n == 4, "R10 wake hold", n + 1, 5);
    cur_req = "R5";
    stay_low(20, "R5 eee off");
    drv(); eee = 1'b1; neg = 1'b0;
    stay_low(20, "R5 not negotiated");
    drv(); neg = 1'b1; txlpi = 1'b0;
    stay_low(20, "R5 tx lpi off");
    drv(); txlpi = 1'b1;
    until_lpi(n);
    chk(n == 1, "R5 all on", n, 1);

    // R7 symmetric
    cur_req = "R7";
    drv(); pend = 1'b1; gig = 1'b1; prdy = 1'b0;
    until_rdy(n);
    drv(); pend = 1'b0;
    stay_low(20, "R7 partner not ready");
    drv(); prdy = 1'b1;
    until_lpi(n);
    chk(n == 1, "R7 partner ready", n, 1);

    // R6 asymmetric
    cur_req = "R6";
    drv(); pend = 1'b1; gig = 1'b0; prdy = 1'b0;
    until_rdy(n);
    drv(); pend = 1'b0;
    until_lpi(n);
    chk(n == 1, "R6 partner ignored", n, 1);

    // R11 pending on the entry cycle
    cur_req = "R11";
    wr(1'b1, 16'h0000);
    wr(1'b0, 16'd3);
    drv(); pend = 1'b1;
    until_rdy(n);
    drv(); pend = 1'b0;
    repeat (3) @(negedge clk);
    #2 pend = 1'b1;
    stay_low(10, "R11 pending wins");

    // R3 slow tick
    cur_req = "R3";
    drv(); pend = 1'b0;
    for (int i = 0; i < 12; i++) begin drv(); tick = ~tick; end
    tick = 1'b0;
    chk(lpi == 1, "R3 half rate tick", lpi, 1);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule